// File: doc/BRIEF.md
# Dual-Mode Program Counter and Conditional-Block Sequencer

This block keeps the architectural program-counter state for a core that executes two instruction sets. One is a fixed 32-bit set (wide mode) and the other is a compact 16/32-bit set (compact mode). It holds the current and next PC, the current and next mode flags, and the size of the instruction now retiring. The mode flags are a compact flag and an execution-environment flag. It also holds an 8-bit conditional-block state and a one-entry pending slot for that state.

The core drives single-cycle strobes into the block. A set-PC command loads an address and a mode. A plain branch, an interworking branch or a wide-only interworking branch rewrites the next PC. An advance strobe retires the current instruction. A load strobe writes the pending conditional-block slot. Branch targets are aligned by their low address bits, and those bits can also choose the next instruction-set mode. On every advance the conditional-block state either takes the pending value or shifts its mask. The outputs give the PC, the next PC, the operand PC that instructions read, the mode flags, the conditional-block state, and a flag that marks a non-sequential next PC. All updates land on the rising clock edge after the strobe.

Top module: `pc_itstate_seq`

## Requirements
- R1: After reset, PC, next PC, both current flags, both next flags and the conditional-block state read zero, the pending slot is empty, and the held instruction size is 4.
- R2: A set-PC command makes PC the given address. Current and next flags both become the given compact and environment flags. Next PC becomes the address plus 2 when the given compact flag is 1, and plus 4 when it is 0.
- R3: The operand PC output equals PC plus 4 when the current compact flag is 1, and PC plus 8 when it is 0.
- R4: An advance moves next PC into PC, copies the next flags into the current flags, and stores the advance size input as the instruction size. Next PC becomes the new PC plus 2 when the new compact flag is 1, and plus 4 when it is 0.
- R5: On an advance with a nonzero pending slot, the conditional-block state takes the pending value and the slot is emptied. A later advance then steps the state and does not reload it.
- R6: On an advance with an empty pending slot and a nonzero state, the state steps as follows. The state holds a condition in bits [7:4] and a mask in bits [3:0]. The mask shifts left by one. The bit shifted out of mask bit 3 becomes condition bit 0. If the shifted mask is zero, the condition becomes zero as well. A zero state stays zero.
- R7: A plain branch writes the target to next PC. Bit 0 is cleared when the next compact flag is 1, and bits [1:0] are cleared when it is 0. The flags are unchanged.
- R8: An interworking branch outside the combined mode looks at the target's low bits. If bit 0 is 1, it sets the next compact flag and clears bit 0. If bits [1:0] are 00, it clears the next compact flag. If bits [1:0] are 10, it clears both bits and keeps the next compact flag.
- R9: In the combined mode (current compact and environment flags both 1), an interworking branch clears target bit 0 and leaves the next compact flag unchanged.
- R10: The wide-only interworking branch acts as an interworking branch when both current flags are 0, and as a plain branch otherwise.
- R11: The branching output is 1 exactly when PC plus the held instruction size differs from next PC.
- R12: When strobes coincide, set-PC wins over any branch, and any branch wins over advance. Among branches, plain wins over interworking, and interworking wins over wide-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Set-PC strobe |
| set_addr | input | AW | Address loaded by set-PC |
| set_compact | input | 1 | Compact flag loaded by set-PC |
| set_env | input | 1 | Environment flag loaded by set-PC |
| br_valid | input | 1 | Plain branch strobe |
| iw_valid | input | 1 | Interworking branch strobe |
| wiw_valid | input | 1 | Wide-only interworking branch strobe |
| br_target | input | AW | Target shared by all branch kinds |
| adv_valid | input | 1 | Advance strobe |
| adv_size | input | SW | Size of the instruction retiring on advance |
| cb_load_valid | input | 1 | Pending conditional-block load strobe |
| cb_load_value | input | 8 | Value written into the pending slot |
| pc | output | AW | Current PC |
| npc | output | AW | Next PC |
| op_pc | output | AW | PC value read as an operand |
| cur_compact | output | 1 | Current compact flag |
| cur_env | output | 1 | Current environment flag |
| nxt_compact | output | 1 | Next compact flag |
| nxt_env | output | 1 | Next environment flag |
| cb_state | output | 8 | Current conditional-block state |
| branching | output | 1 | Next PC is not PC plus size |

## Verification
The branch resolver is tested across every pairing of the two current flags with each branch kind. Targets end in 00, 01, 10 and 11, so the plain-alignment, interworking-switch and combined-mode paths each produce a different next PC or next compact flag. The conditional-block stepping is driven through a mask whose shifted-out bits alternate between 1 and 0 until the mask empties. A pending load lands while the state is nonzero, so a reload can be told apart from a step. Coinciding strobes are chosen so that each losing command would have left a visibly different PC, next PC or mode flag.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef struct packed {
        logic compact;
        logic env;
    } mode_t;

    typedef enum logic [1:0] {
        BR_PLAIN   = 2'd0,
        BR_IW      = 2'd1,
        BR_WIDE_IW = 2'd2
    } br_kind_t;

    localparam int unsigned CB_FIELD_W = 4;
    localparam int unsigned CB_W       = 2 * CB_FIELD_W;

endpackage

// File: rtl/pcseq_incr.sv
module pcseq_incr #(
    parameter int unsigned AW     = 32,
    parameter int unsigned STEP_C = 2,
    parameter int unsigned STEP_W = 4
) (
    input  logic [AW-1:0] base,
    input  logic          compact,
    output logic [AW-1:0] sum
);
    localparam logic [AW-1:0] INC_C = AW'(STEP_C);
    localparam logic [AW-1:0] INC_W = AW'(STEP_W);

    assign sum = base + (compact ? INC_C : INC_W);
endmodule

// File: rtl/pcseq_itstep.sv
module pcseq_itstep #(
    parameter int unsigned FW = 4
) (
    input  logic [2*FW-1:0] cur,
    input  logic [2*FW-1:0] pend,
    output logic [2*FW-1:0] nxt
);
    logic [FW-1:0] cond_q, mask_q, cond_n, mask_n;
    logic          spill;

    assign cond_q = cur[2*FW-1:FW];
    assign mask_q = cur[FW-1:0];

    always_comb begin
        mask_n = {mask_q[FW-2:0], 1'b0};
        spill  = mask_q[FW-1];
        cond_n = cond_q;
        if (mask_n == '0) begin
            cond_n = '0;
        end else begin
            cond_n[0] = spill;
        end

        if (pend != '0) begin
            nxt = pend;
        end else if (cur != '0) begin
            nxt = {cond_n, mask_n};
        end else begin
            nxt = '0;
        end
    end
endmodule

// File: rtl/pcseq_target.sv
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  br_kind_t      kind,
    input  mode_t         cur_mode,
    input  logic          nxt_compact_in,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] npc_out,
    output logic          nxt_compact_out
);
    logic          do_iw;
    logic          combined;
    logic [AW-1:0] clr1, clr2;

    assign clr1     = {target[AW-1:1], 1'b0};
    assign clr2     = {target[AW-1:2], 2'b00};
    assign combined = cur_mode.compact & cur_mode.env;

    always_comb begin
        unique case (kind)
            BR_IW:      do_iw = 1'b1;
            BR_WIDE_IW: do_iw = !cur_mode.compact && !cur_mode.env;
            default:    do_iw = 1'b0;
        endcase

        nxt_compact_out = nxt_compact_in;
        npc_out         = target;
        if (!do_iw) begin
            npc_out = nxt_compact_in ? clr1 : clr2;
        end else if (combined) begin
            npc_out = clr1;
        end else if (target[0]) begin
            nxt_compact_out = 1'b1;
            npc_out         = clr1;
        end else if (!target[1]) begin
            nxt_compact_out = 1'b0;
            npc_out         = target;
        end else begin
            npc_out = clr2;
        end
    end
endmodule

// File: rtl/pc_itstate_seq.sv
module pc_itstate_seq
    import pcseq_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned SW       = 3,
    parameter int unsigned SIZE_RST = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_valid,
    input  logic [AW-1:0] set_addr,
    input  logic          set_compact,
    input  logic          set_env,
    input  logic          br_valid,
    input  logic          iw_valid,
    input  logic          wiw_valid,
    input  logic [AW-1:0] br_target,
    input  logic          adv_valid,
    input  logic [SW-1:0] adv_size,
    input  logic          cb_load_valid,
    input  logic [7:0]    cb_load_value,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] npc,
    output logic [AW-1:0] op_pc,
    output logic          cur_compact,
    output logic          cur_env,
    output logic          nxt_compact,
    output logic          nxt_env,
    output logic [7:0]    cb_state,
    output logic          branching
);
    localparam logic [SW-1:0] SIZE_INIT = SW'(SIZE_RST);

    typedef struct packed {
        logic [AW-1:0]   pc;
        logic [AW-1:0]   npc;
        mode_t           cur;
        mode_t           nxt;
        logic [SW-1:0]   size;
        logic [CB_W-1:0] cb;
        logic [CB_W-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    logic          br_any;
    br_kind_t      br_kind;
    logic [AW-1:0] set_step, adv_step, tgt_npc;
    logic          tgt_nc;
    logic [CB_W-1:0] cb_adv;

    assign br_any = br_valid | iw_valid | wiw_valid;

    always_comb begin
        if (br_valid)      br_kind = BR_PLAIN;
        else if (iw_valid) br_kind = BR_IW;
        else               br_kind = BR_WIDE_IW;
    end

    pcseq_incr #(.AW(AW), .STEP_C(2), .STEP_W(4)) u_set_step (
        .base(set_addr), .compact(set_compact), .sum(set_step)
    );

    pcseq_incr #(.AW(AW), .STEP_C(2), .STEP_W(4)) u_adv_step (
        .base(st_q.npc), .compact(st_q.nxt.compact), .sum(adv_step)
    );

    pcseq_incr #(.AW(AW), .STEP_C(4), .STEP_W(8)) u_op_pc (
        .base(st_q.pc), .compact(st_q.cur.compact), .sum(op_pc)
    );

    pcseq_target #(.AW(AW)) u_target (
        .kind(br_kind), .cur_mode(st_q.cur), .nxt_compact_in(st_q.nxt.compact),
        .target(br_target), .npc_out(tgt_npc), .nxt_compact_out(tgt_nc)
    );

    pcseq_itstep #(.FW(CB_FIELD_W)) u_itstep (
        .cur(st_q.cb), .pend(st_q.pend), .nxt(cb_adv)
    );

    always_comb begin
        st_d = st_q;
        if (set_valid) begin
            st_d.pc          = set_addr;
            st_d.npc         = set_step;
            st_d.cur.compact = set_compact;
            st_d.cur.env     = set_env;
            st_d.nxt.compact = set_compact;
            st_d.nxt.env     = set_env;
        end else if (br_any) begin
            st_d.npc         = tgt_npc;
            st_d.nxt.compact = tgt_nc;
        end else if (adv_valid) begin
            st_d.pc   = st_q.npc;
            st_d.cur  = st_q.nxt;
            st_d.npc  = adv_step;
            st_d.size = adv_size;
            st_d.cb   = cb_adv;
            st_d.pend = '0;
        end
        if (cb_load_valid) begin
            st_d.pend = cb_load_value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.size <= SIZE_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc          = st_q.pc;
    assign npc         = st_q.npc;
    assign cur_compact = st_q.cur.compact;
    assign cur_env     = st_q.cur.env;
    assign nxt_compact = st_q.nxt.compact;
    assign nxt_env     = st_q.nxt.env;
    assign cb_state    = st_q.cb;
    assign branching   = (st_q.pc + AW'(st_q.size)) != st_q.npc;

    logic adv_only;
    assign adv_only = adv_valid && !set_valid && !br_any;

    p_set_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> (npc == pc + (cur_compact ? AW'(2) : AW'(4))));

    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> (pc == $past(set_addr)));

    p_adv_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adv_only |=> (pc == $past(npc)) && (cur_compact == $past(nxt_compact))
                     && (cur_env == $past(nxt_env)));

    p_pend_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_only && st_q.pend != '0) |=> (cb_state == $past(st_q.pend)));

    p_mask_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_only && st_q.pend == '0 && st_q.cb != '0)
        |=> (cb_state[3:0] == {$past(cb_state[2:0]), 1'b0})
            && ((cb_state[3:0] != 4'h0) || (cb_state[7:4] == 4'h0)));

    p_plain_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !set_valid) |=> (nxt_compact ? (npc[0] == 1'b0) : (npc[1:0] == 2'b00)));

    p_combined_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_valid && !br_valid && !set_valid && cur_compact && cur_env)
        |=> (nxt_compact == $past(nxt_compact)) && (npc[0] == 1'b0));
endmodule

// File: tb/pc_itstate_seq_tb_top.sv
module pc_itstate_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int SW = 3;

    typedef struct packed {
        logic        cc;
        logic        ce;
        logic [1:0]  kind;   // 0 plain, 1 interworking, 2 wide-only
        logic [31:0] tgt;
        logic [31:0] enpc;
        logic        enc;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 13;
    localparam row_t TBL [NROWS] = '{
        '{1'b0, 1'b0, 2'd0, 32'h1003, 32'h1000, 1'b0, 4'd7},  // R7 wide next mode
        '{1'b1, 1'b0, 2'd0, 32'h1003, 32'h1002, 1'b1, 4'd7},  // R7 compact next mode
        '{1'b0, 1'b0, 2'd1, 32'h2001, 32'h2000, 1'b1, 4'd8},  // R8 bit0 set
        '{1'b1, 1'b0, 2'd1, 32'h2004, 32'h2004, 1'b0, 4'd8},  // R8 bits 00
        '{1'b0, 1'b0, 2'd1, 32'h2006, 32'h2004, 1'b0, 4'd8},  // R8 bits 10 keep wide
        '{1'b1, 1'b0, 2'd1, 32'h2006, 32'h2004, 1'b1, 4'd8},  // R8 bits 10 keep compact
        '{1'b1, 1'b1, 2'd1, 32'h3001, 32'h3000, 1'b1, 4'd9},  // R9 clear bit0
        '{1'b1, 1'b1, 2'd1, 32'h3002, 32'h3002, 1'b1, 4'd9},  // R9 pass through
        '{1'b0, 1'b1, 2'd1, 32'h2001, 32'h2000, 1'b1, 4'd8},  // R8 env alone is not combined
        '{1'b0, 1'b0, 2'd2, 32'h4001, 32'h4000, 1'b1, 4'd10}, // R10 acts as interworking
        '{1'b1, 1'b0, 2'd2, 32'h4003, 32'h4002, 1'b1, 4'd10}, // R10 plain in compact
        '{1'b0, 1'b1, 2'd2, 32'h4001, 32'h4000, 1'b0, 4'd10}, // R10 plain with env
        '{1'b1, 1'b1, 2'd2, 32'h4003, 32'h4002, 1'b1, 4'd10}  // R10 plain in combined
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          set_valid, set_compact, set_env;
    logic [AW-1:0] set_addr;
    logic          br_valid, iw_valid, wiw_valid;
    logic [AW-1:0] br_target;
    logic          adv_valid;
    logic [SW-1:0] adv_size;
    logic          cb_load_valid;
    logic [7:0]    cb_load_value;
    logic [AW-1:0] pc, npc, op_pc;
    logic          cur_compact, cur_env, nxt_compact, nxt_env, branching;
    logic [7:0]    cb_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_itstate_seq #(.AW(AW), .SW(SW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .set_valid(set_valid), .set_addr(set_addr), .set_compact(set_compact), .set_env(set_env),
        .br_valid(br_valid), .iw_valid(iw_valid), .wiw_valid(wiw_valid), .br_target(br_target),
        .adv_valid(adv_valid), .adv_size(adv_size),
        .cb_load_valid(cb_load_valid), .cb_load_value(cb_load_value),
        .pc(pc), .npc(npc), .op_pc(op_pc),
        .cur_compact(cur_compact), .cur_env(cur_env),
        .nxt_compact(nxt_compact), .nxt_env(nxt_env),
        .cb_state(cb_state), .branching(branching)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic idle();
        set_valid = 0; set_addr = '0; set_compact = 0; set_env = 0;
        br_valid = 0; iw_valid = 0; wiw_valid = 0; br_target = '0;
        adv_valid = 0; adv_size = 3'd4; cb_load_valid = 0; cb_load_value = '0;
    endtask

    // strobes were driven at a falling edge; one rising edge registers them
    task automatic pulse();
        @(negedge clk);
        idle();
    endtask

    task automatic do_set(input logic [31:0] a, input logic c, input logic e);
        set_valid = 1; set_addr = a; set_compact = c; set_env = e;
        pulse();
    endtask

    task automatic do_adv(input logic [2:0] s);
        adv_valid = 1; adv_size = s;
        pulse();
    endtask

    task automatic do_load(input logic [7:0] v);
        cb_load_valid = 1; cb_load_value = v;
        pulse();
    endtask

    initial begin
        for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pc", pc, 32'h0);
        chk("R1 npc", npc, 32'h0);
        chk("R1 flags", {28'h0, cur_compact, cur_env, nxt_compact, nxt_env}, 32'h0);
        chk("R1 cb_state", cb_state, 32'h0);
        chk("R3 operand pc wide", op_pc, 32'h8);
        chk("R11 reset size 4 vs npc 0", branching, 1'b1);

        // R2 set in wide mode
        do_set(32'h100, 0, 0);
        chk("R2 pc", pc, 32'h100);
        chk("R2 npc wide", npc, 32'h104);
        chk("R3 operand pc wide", op_pc, 32'h108);
        chk("R11 sequential", branching, 1'b0);

        // R2 set in compact mode; size still 4
        do_set(32'h200, 1, 0);
        chk("R2 npc compact", npc, 32'h202);
        chk("R2 flags", {28'h0, cur_compact, cur_env, nxt_compact, nxt_env}, 32'hA);
        chk("R3 operand pc compact", op_pc, 32'h204);
        chk("R11 size mismatch", branching, 1'b1);

        // R4 advance with size 2
        do_adv(3'd2);
        chk("R4 pc", pc, 32'h202);
        chk("R4 npc", npc, 32'h204);
        chk("R11 after advance", branching, 1'b0);

        // R4 mode switch carried by advance
        do_set(32'h300, 0, 0);
        iw_valid = 1; br_target = 32'h301;
        pulse();
        chk("R8 switch npc", npc, 32'h300);
        chk("R8 switch next compact", nxt_compact, 1'b1);
        chk("R8 current untouched", cur_compact, 1'b0);
        do_adv(3'd4);
        chk("R4 pc", pc, 32'h300);
        chk("R4 cur compact", cur_compact, 1'b1);
        chk("R4 npc compact step", npc, 32'h302);
        chk("R3 operand pc", op_pc, 32'h304);
        chk("R11 size 4 vs step 2", branching, 1'b1);

        // R5/R6 conditional-block sequence
        do_load(8'h5A);
        chk("R5 pending not yet visible", cb_state, 8'h00);
        do_adv(3'd2);
        chk("R5 pending loaded", cb_state, 8'h5A);
        do_adv(3'd2);
        chk("R6 shift out 1", cb_state, 8'h54);
        do_load(8'h1F);
        do_adv(3'd2);
        chk("R5 reload over nonzero", cb_state, 8'h1F);
        do_adv(3'd2);
        chk("R6 step 1F", cb_state, 8'h1E);
        do_load(8'h48);
        do_adv(3'd2);
        chk("R5 load 48", cb_state, 8'h48);
        do_adv(3'd2);
        chk("R6 mask empties clears cond", cb_state, 8'h00);
        do_adv(3'd2);
        chk("R5 slot emptied, R6 zero stays", cb_state, 8'h00);

        // R12 priorities
        set_valid = 1; set_addr = 32'h500; br_valid = 1; br_target = 32'h900;
        pulse();
        chk("R12 set over branch pc", pc, 32'h500);
        chk("R12 set over branch npc", npc, 32'h504);
        br_valid = 1; br_target = 32'h900; adv_valid = 1;
        pulse();
        chk("R12 branch over advance pc", pc, 32'h500);
        chk("R12 branch over advance npc", npc, 32'h900);
        chk("R11 taken branch", branching, 1'b1);
        br_valid = 1; iw_valid = 1; br_target = 32'h703;
        pulse();
        chk("R12 plain over interworking npc", npc, 32'h700);
        chk("R12 plain over interworking mode", nxt_compact, 1'b0);
        iw_valid = 1; wiw_valid = 1; br_target = 32'h701;
        do_set(32'h500, 1, 0);
        iw_valid = 1; wiw_valid = 1; br_target = 32'h702;
        pulse();
        chk("R12 interworking over wide-only npc", npc, 32'h700);

        // branch resolver table: R7 R8 R9 R10
        for (int i = 0; i < NROWS; i++) begin
            do_set(32'h8000, TBL[i].cc, TBL[i].ce);
            br_target = TBL[i].tgt;
            case (TBL[i].kind)
                2'd0:    br_valid  = 1;
                2'd1:    iw_valid  = 1;
                default: wiw_valid = 1;
            endcase
            pulse();
            chk($sformatf("R%0d row %0d npc", TBL[i].req, i), npc, TBL[i].enpc);
            chk($sformatf("R%0d row %0d next compact", TBL[i].req, i), nxt_compact, TBL[i].enc);
            chk($sformatf("R%0d row %0d current flags kept", TBL[i].req, i),
                {cur_compact, cur_env}, {TBL[i].cc, TBL[i].ce});
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule